// File: doc/BRIEF.md
# Center-Aligned Four-Channel PWM Generator

This block produces four pulse-width-modulated outputs from one shared time base, in the style used to drive the bridge of an electric motor. The time base counts in whole steps up to a programmable period value. Each step lasts two clocks, and a phase bit splits each step into two half-steps. The position that the channels compare against is therefore the step count with the phase bit appended. This gives every 16-bit duty value half-step resolution against a 15-bit period.

The time base runs in one of three ways. It can count up and wrap, which gives edge-aligned pulses. It can count up and then down, which gives pulses centered on the zero point. It can also count up and down with a second update point at the top of the count. Every channel keeps a duty buffer that writes go into, and a shadow value that drives its comparator. The buffer moves into the shadow at the point the mode selects. It moves continuously while the time base is stopped. With immediate update selected, it moves on the clock after each write.

The period, mode and update controls are expected to stay constant while the time base runs. A change is made by dropping the enable, reprogramming, and enabling again.

Top module: `pwm_center_gen`

## Requirements
- R1: After reset all four outputs and the direction output are low, and the time base rests at position zero.
- R2: With mode 0 (edge-aligned) the step counter runs 0 to P and wraps, so the period is 2(P+1) clocks. Each channel is active from the start of the period for min(D, 2P+2) clocks, where the position is the step count times two plus the phase bit. An odd duty gives an odd number of active clocks.
- R3: With mode 1 or 2 (center) the counter rises from 0 to P and then falls back to 0. It holds one step at each end, so the period is 4(P+1) clocks. A channel turns on as the falling position passes below D and turns off as the rising position reaches D, which gives 2·min(D, 2P+2) active clocks. The direction output is high for the 2(P+1) clocks of the falling half.
- R4: A duty of 0 keeps a channel low for the whole period. A duty of 2P+2 or more keeps it high for the whole period.
- R5: A buffered write does not change the output until the next load point. In mode 0 the load point is the wrap from P to 0.
- R6: While the update-disable input is high, no load point moves a buffer into its shadow.
- R7: In mode 1 shadows load only at the bottom turn, so a whole falling half uses the previous duty. In mode 2 they also load at the top turn, so the falling half right after a write already uses the new duty.
- R8: While the enable input is low, all outputs are low, each shadow follows its buffer, and the counter is held at zero. On enable the count starts at zero going up, with the new duties already in force.
- R9: With immediate update set, a write reaches the channel's shadow on the next clock. An inactive output whose new duty exceeds the position turns on at once. An active output whose new duty falls below the position turns off at once.
- R10: The write port selects the channel by its 2-bit index. The channels share the time base but keep independent duties.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Time base run enable |
| mode_i | input | 2 | 0 edge-aligned, 1 center, 2 center with top update, 3 same as 1 |
| period_i | input | 15 | Period P in whole steps |
| upd_dis_i | input | 1 | Blocks the period-point shadow loads |
| imm_i | input | 1 | Writes go straight to the shadow |
| wr_en_i | input | 1 | Duty write strobe |
| wr_ch_i | input | 2 | Channel index of the write |
| wr_data_i | input | 16 | Duty value in half steps |
| pwm_o | output | 4 | Channel outputs, bit n is channel n |
| dir_o | output | 1 | High while the count falls |

## Verification
The checks assume that the mode and the period do not change while the time base runs. Under that assumption the shadows can change only at a load point, on an immediate write, or while the block is stopped. The direction can rise only in a center mode. The bench reprograms the block only while it is disabled, so every stimulus stays inside that contract. It times each write against the observed direction edges, so that a write lands well clear of any load point.

// File: rtl/pwm_ca_pkg.sv
package pwm_ca_pkg;

    typedef enum logic [1:0] {
        TB_EDGE       = 2'd0,
        TB_CENTER     = 2'd1,
        TB_CENTER_DBL = 2'd2,
        TB_CENTER_ALT = 2'd3
    } tb_mode_e;

    function automatic logic is_edge(input logic [1:0] mode);
        return mode == TB_EDGE;
    endfunction

    function automatic logic has_top_load(input logic [1:0] mode);
        return mode == TB_CENTER_DBL;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_ca_pkg::*;
#(
    parameter int unsigned CNT_W = 15,
    localparam int unsigned POS_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [POS_W-1:0] pos_o,
    output logic             dir_o,
    output logic             wrap_o,
    output logic             bottom_o,
    output logic             top_o
);

    typedef struct packed {
        logic [CNT_W-1:0] tmr;
        logic             ph;
        logic             dir;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        wrap_o   = 1'b0;
        bottom_o = 1'b0;
        top_o    = 1'b0;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.ph = ~st_q.ph;
            if (is_edge(mode_i)) begin
                st_d.dir = 1'b0;
            end
            if (st_q.ph) begin
                if (is_edge(mode_i)) begin
                    if (st_q.tmr >= period_i) begin
                        st_d.tmr = '0;
                        wrap_o   = 1'b1;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end else if (!st_q.dir) begin
                    if (st_q.tmr >= period_i) begin
                        st_d.dir = 1'b1;
                        top_o    = 1'b1;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end else begin
                    if (st_q.tmr == '0) begin
                        st_d.dir = 1'b0;
                        bottom_o = 1'b1;
                    end else begin
                        st_d.tmr = st_q.tmr - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // falling half walks the half-steps in reverse so each position appears once per half
    assign pos_o = {st_q.tmr, st_q.ph ^ st_q.dir};
    assign dir_o = st_q.dir;

endmodule

// File: rtl/pwm_load_sel.sv
module pwm_load_sel
    import pwm_ca_pkg::*;
(
    input  logic       en_i,
    input  logic [1:0] mode_i,
    input  logic       upd_dis_i,
    input  logic       wrap_i,
    input  logic       bottom_i,
    input  logic       top_i,
    output logic       load_o
);

    logic point;

    always_comb begin
        if (is_edge(mode_i)) begin
            point = wrap_i;
        end else begin
            point = bottom_i | (has_top_load(mode_i) & top_i);
        end
        load_o = en_i & ~upd_dis_i & point;
    end

endmodule

// File: rtl/pwm_duty_chan.sv
module pwm_duty_chan #(
    parameter int unsigned DUTY_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              imm_i,
    input  logic              wr_hit_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    input  logic              load_i,
    input  logic [DUTY_W-1:0] pos_i,
    output logic [DUTY_W-1:0] shadow_o,
    output logic              pwm_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] dbuf;
        logic [DUTY_W-1:0] shd;
    } chan_state_t;

    chan_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (wr_hit_i) begin
            cs_d.dbuf = wr_data_i;
        end
        if (!en_i) begin
            cs_d.shd = cs_d.dbuf;
        end else if (imm_i && wr_hit_i) begin
            cs_d.shd = wr_data_i;
        end else if (load_i) begin
            cs_d.shd = cs_q.dbuf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign shadow_o = cs_q.shd;
    assign pwm_o    = en_i & (pos_i < cs_q.shd);

endmodule

// File: rtl/pwm_center_gen.sv
module pwm_center_gen
    import pwm_ca_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DUTY_W = 16,
    localparam int unsigned CNT_W = DUTY_W - 1,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              upd_dis_i,
    input  logic              imm_i,
    input  logic              wr_en_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              dir_o
);

    logic [DUTY_W-1:0]        pos_w;
    logic                     wrap_w;
    logic                     bottom_w;
    logic                     top_w;
    logic                     load_w;
    logic [NUM_CH*DUTY_W-1:0] shadow_flat;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .mode_i   (mode_i),
        .period_i (period_i),
        .pos_o    (pos_w),
        .dir_o    (dir_o),
        .wrap_o   (wrap_w),
        .bottom_o (bottom_w),
        .top_o    (top_w)
    );

    pwm_load_sel u_ld (
        .en_i      (en_i),
        .mode_i    (mode_i),
        .upd_dis_i (upd_dis_i),
        .wrap_i    (wrap_w),
        .bottom_i  (bottom_w),
        .top_i     (top_w),
        .load_o    (load_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en_i && (wr_ch_i == CH_W'(g));

        pwm_duty_chan #(.DUTY_W(DUTY_W)) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (en_i),
            .imm_i     (imm_i),
            .wr_hit_i  (hit),
            .wr_data_i (wr_data_i),
            .load_i    (load_w),
            .pos_i     (pos_w),
            .shadow_o  (shadow_flat[g*DUTY_W +: DUTY_W]),
            .pwm_o     (pwm_o[g])
        );
    end

endmodule

// File: rtl/pwm_ca_chk.sv
module pwm_ca_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DUTY_W = 16,
    parameter int unsigned CH_W   = 2
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     en_i,
    input logic [1:0]               mode_i,
    input logic                     upd_dis_i,
    input logic                     imm_i,
    input logic                     wr_en_i,
    input logic [CH_W-1:0]          wr_ch_i,
    input logic [DUTY_W-1:0]        wr_data_i,
    input logic [NUM_CH-1:0]        pwm_o,
    input logic                     dir_o,
    input logic                     load_i,
    input logic [NUM_CH*DUTY_W-1:0] shadow_i
);

    logic [CH_W-1:0]   prev_ch_q;
    logic [DUTY_W-1:0] prev_data_q;
    logic [DUTY_W-1:0] sel_shadow;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_ch_q   <= '0;
            prev_data_q <= '0;
        end else begin
            prev_ch_q   <= wr_ch_i;
            prev_data_q <= wr_data_i;
        end
    end

    always_comb begin
        sel_shadow = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (prev_ch_q == CH_W'(i)) begin
                sel_shadow = shadow_i[i*DUTY_W +: DUTY_W];
            end
        end
    end

    a_r8_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> pwm_o == '0);

    a_r8_idle_dir_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i) |-> !dir_o);

    a_r2_edge_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i && mode_i == 2'd0) |-> !dir_o);

    a_r3_turn_in_center: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dir_o) |-> $past(mode_i) != 2'd0);

    a_r5_shadow_moves_at_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i && !load_i && !(imm_i && wr_en_i)) |-> $stable(shadow_i));

    a_r6_upd_dis_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i && upd_dis_i && !(imm_i && wr_en_i)) |-> $stable(shadow_i));

    a_r9_imm_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && imm_i) |-> sel_shadow == prev_data_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_zero
        a_r4_zero_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
            shadow_i[g*DUTY_W +: DUTY_W] == '0 |-> !pwm_o[g]);
    end

endmodule

bind pwm_center_gen pwm_ca_chk #(
    .NUM_CH (NUM_CH),
    .DUTY_W (DUTY_W),
    .CH_W   (CH_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .upd_dis_i (upd_dis_i),
    .imm_i     (imm_i),
    .wr_en_i   (wr_en_i),
    .wr_ch_i   (wr_ch_i),
    .wr_data_i (wr_data_i),
    .pwm_o     (pwm_o),
    .dir_o     (dir_o),
    .load_i    (load_w),
    .shadow_i  (shadow_flat)
);

// File: tb/tb_pwm_center_gen.sv
module tb_pwm_center_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [14:0] period = 15'd5;
    logic        upd_dis = 1'b0;
    logic        imm = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [3:0]  pwm;
    logic        dir;

    int n_chk = 0;
    int n_fail = 0;
    int cnt [4];
    int dir_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_center_gen dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .mode_i    (mode),
        .period_i  (period),
        .upd_dis_i (upd_dis),
        .imm_i     (imm),
        .wr_en_i   (wr_en),
        .wr_ch_i   (wr_ch),
        .wr_data_i (wr_data),
        .pwm_o     (pwm),
        .dir_o     (dir)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int val);
        @(negedge clk);
        wr_en = 1'b1;
        wr_ch = 2'(ch);
        wr_data = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic configure(input int m, input int p, input int d0, input int d1,
                             input int d2, input int d3);
        @(negedge clk);
        en = 1'b0;
        imm = 1'b0;
        upd_dis = 1'b0;
        mode = 2'(m);
        period = 15'(p);
        wr(0, d0);
        wr(1, d1);
        wr(2, d2);
        wr(3, d3);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic measure(input int len);
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        dir_cnt = 0;
        repeat (len) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) if (pwm[c]) cnt[c]++;
            if (dir) dir_cnt++;
        end
    endtask

    task automatic wait_dir_fall();
        logic prev;
        logic seen;
        prev = dir;
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            if (prev && !dir) seen = 1'b1;
            prev = dir;
        end
    endtask

    function automatic int full_lim(input int d, input int p);
        return (d < 2*p+2) ? d : 2*p+2;
    endfunction

    task automatic t_reset();
        chk("R1 pwm after reset", int'(pwm), 0);
        chk("R1 dir after reset", int'(dir), 0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        en = 1'b0;
        mode = 2'd0;
        period = 15'd5;
        wr(2, 9);
        repeat (3) @(negedge clk);
        chk("R8 outputs low while stopped", int'(pwm), 0);
        en = 1'b1;
        #1;
        chk("R8 shadow follows buffer while stopped", int'(pwm[2]), 1);
        measure(12);
        chk("R8 ch2 width after enable", cnt[2], 9);
    endtask

    task automatic t_edge();
        int d [4];
        d = '{0, 7, 12, 3};
        configure(0, 5, d[0], d[1], d[2], d[3]);
        repeat (5) @(negedge clk);
        measure(12);
        for (int c = 0; c < 4; c++) chk("R2 R4 R10 edge width P=5", cnt[c], full_lim(d[c], 5));
        chk("R2 dir stays low in edge mode", dir_cnt, 0);
        d = '{19, 1, 25, 20};
        configure(0, 9, d[0], d[1], d[2], d[3]);
        repeat (7) @(negedge clk);
        measure(20);
        for (int c = 0; c < 4; c++) chk("R2 R4 edge width P=9", cnt[c], full_lim(d[c], 9));
    endtask

    task automatic t_center();
        int d [4];
        d = '{0, 7, 13, 3};
        configure(1, 5, d[0], d[1], d[2], d[3]);
        repeat (9) @(negedge clk);
        measure(24);
        for (int c = 0; c < 4; c++) chk("R3 R4 center width P=5", cnt[c], 2*full_lim(d[c], 5));
        chk("R3 falling half length", dir_cnt, 12);
    endtask

    task automatic t_upd_dis();
        configure(0, 5, 0, 7, 0, 0);
        repeat (4) @(negedge clk);
        upd_dis = 1'b1;
        wr(1, 2);
        repeat (30) @(negedge clk);
        measure(12);
        chk("R6 R5 update-disable keeps old duty", cnt[1], 7);
        upd_dis = 1'b0;
        repeat (14) @(negedge clk);
        measure(12);
        chk("R5 duty taken at period wrap", cnt[1], 2);
    endtask

    task automatic t_load_point(input int m, input int exp_fall);
        int c0;
        configure(m, 10, 4, 0, 0, 0);
        wait_dir_fall();
        repeat (3) @(negedge clk);
        wr(0, 10);
        while (!dir) @(negedge clk);
        c0 = 0;
        do begin
            if (pwm[0]) c0++;
            @(negedge clk);
        end while (dir);
        chk("R7 falling half after write", c0, exp_fall);
        c0 = 0;
        do begin
            if (pwm[0]) c0++;
            @(negedge clk);
        end while (!dir);
        chk("R7 rising half after bottom load", c0, 10);
    endtask

    task automatic t_immediate();
        configure(1, 20, 4, 0, 0, 0);
        imm = 1'b1;
        wait_dir_fall();
        repeat (10) @(negedge clk);
        chk("R9 output low before write", int'(pwm[0]), 0);
        wr(0, 60);
        chk("R9 raised duty turns output on at once", int'(pwm[0]), 1);
        repeat (5) @(negedge clk);
        wr(0, 3);
        chk("R9 lowered duty cuts pulse at once", int'(pwm[0]), 0);
        imm = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_edge();
        t_center();
        t_upd_dis();
        t_load_point(1, 4);
        t_load_point(2, 10);
        t_immediate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule